// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Fill Flags

This block is a one-direction queue of 512 words of 18 bits. It moves data from a write clock domain to a read clock domain. The two free-running clocks are independent: they may be unrelated or the same. The producer pushes a word on a rising write-clock edge while it holds its enable high and the input-ready flag is high. The consumer sees the oldest unread word on a registered output, without asking for it. The output-ready flag is high while that word is valid and not yet taken. A read enable on a rising read-clock edge consumes the word.

Each side keeps its own binary pointer and publishes a registered Gray copy of it. The other domain takes that copy through a two-flop synchronizer. The read side publishes its *consumed* pointer, which counts words taken by a read. The word waiting in the output register therefore keeps its storage slot reserved, and the capacity stays at exactly 512.

The write domain derives three more outputs from its own pointer and the synchronized consumed pointer:
- the input-ready flag;
- a half-full flag;
- an almost-full/almost-empty flag, set by an offset captured around reset.

Top module: `xfifo_top`

## Requirements
- R1: A word is stored on a rising `wr_clk_i` edge when `wr_en_i` and `in_rdy_o` are both high, and words reach `rd_data_o` in the order they were stored, across pointer wrap.
- R2: `in_rdy_o` is low exactly while 512 stored words are not yet consumed. A write attempted while it is low is dropped and never reaches the output.
- R3: While `out_rdy_o` is low, `rd_en_i` has no effect: it consumes nothing and moves no pointer.
- R4: When a word enters an empty FIFO, it is loaded into the output register on the same read-clock edge that raises `out_rdy_o`, with no read request.
- R5: After the last word is consumed, `out_rdy_o` goes low and `rd_data_o` keeps that last word until `out_rdy_o` rises again.
- R6: While `out_rdy_o` is high and `rd_en_i` is low, `out_rdy_o` stays high and `rd_data_o` does not change.
- R7: The fill level is the number of words stored minus the number consumed, as seen in the write domain. `half_full_o` is high when this level is 256 or more.
- R8: `almost_o` is high when the level is at most the offset or at least 512 minus the offset. The offset is taken from `af_ae_off_i` on `wr_clk_i` edges during reset and on the first edge after it.
- R9: While `rst_ni` is low, the outputs are: `in_rdy_o`=1, `out_rdy_o`=0, `rd_data_o`=0, `half_full_o`=0 and `almost_o`=1.
- R10: Each pointer sent across the clock boundary changes at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-side clock |
| rd_clk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low, for both domains |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 18 | Word to store |
| af_ae_off_i | input | 9 | Almost-full/almost-empty offset, captured around reset |
| rd_en_i | input | 1 | Consume the word shown on `rd_data_o` |
| in_rdy_o | output | 1 | FIFO can accept a word (write domain) |
| out_rdy_o | output | 1 | `rd_data_o` holds a valid unread word (read domain) |
| rd_data_o | output | 18 | Registered output word |
| half_full_o | output | 1 | Level of 256 or more (write domain) |
| almost_o | output | 1 | Level within the offset of empty or of full (write domain) |

## Verification
A table of fill levels fills the FIFO step by step from empty to full with no reads, using an offset of 16. The steps land on each side of every flag threshold (0, 10, 16/17, 255/256, 495/496, 512). This separates an off-by-one on either side of a compare and shows that the output register keeps the first word throughout.

A full drain follows, after writes were attempted while full. It shows that the order is kept across pointer wrap and that the dropped words never appear.

Reads requested while empty are then followed by a level check. A wrongly counted read would leave a wrapped, large level.

Last, a single word written into an empty FIFO is watched one read edge at a time. This separates a true fall-through, where the data and flag rise together, from a one-cycle-late data load or a lost held word.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int unsigned ADDR_W      = 9;
  localparam int unsigned DATA_W      = 18;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int unsigned W      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 18
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // slot is written at least two read edges before it is addressed
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl #(
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_req_i,
  input  logic [AW:0]   rgray_i,
  input  logic [AW-1:0] off_cfg_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          in_rdy_o,
  output logic          half_o,
  output logic          almost_o
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_q, wbin_nxt, rbin, lvl_nxt, off_ext;
  logic [PW-1:0] wgray_q;
  logic [AW-1:0] off_q;
  logic          full_q, half_q, alm_q, cfg_open_q, push;

  assign push     = push_req_i & ~full_q;
  assign wbin_nxt = wbin_q + PW'(push);
  assign rbin     = g2b(rgray_i);
  assign lvl_nxt  = wbin_nxt - rbin;
  assign off_ext  = {1'b0, off_q};

  // open during reset and for the first edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_open_q <= 1'b1;
    else         cfg_open_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (cfg_open_q) off_q <= off_cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
      alm_q   <= 1'b1;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= b2g(wbin_nxt);
      full_q  <= (lvl_nxt == PW'(DEPTH));
      half_q  <= (lvl_nxt >= PW'(DEPTH / 2));
      alm_q   <= (lvl_nxt <= off_ext) || (lvl_nxt >= PW'(DEPTH) - off_ext);
    end
  end

  assign we_o     = push;
  assign waddr_o  = wbin_q[AW-1:0];
  assign wgray_o  = wgray_q;
  assign in_rdy_o = ~full_q;
  assign half_o   = half_q;
  assign almost_o = alm_q;
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_req_i,
  input  logic [AW:0]   wgray_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          out_rdy_o,
  output logic [DW-1:0] dout_o
);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [PW-1:0] fetch_q, cons_q, cons_nxt, rgray_q;
  logic [DW-1:0] dout_q;
  logic          valid_q, mem_empty, pop, load;

  assign mem_empty = (b2g(fetch_q) == wgray_i);
  assign pop       = pop_req_i & valid_q;
  assign load      = (~valid_q | pop) & ~mem_empty;
  assign cons_nxt  = cons_q + PW'(pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= '0;
      cons_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      fetch_q <= fetch_q + PW'(load);
      cons_q  <= cons_nxt;
      rgray_q <= b2g(cons_nxt);
      valid_q <= load | (valid_q & ~pop);
      if (load) dout_q <= rdata_i;
    end
  end

  assign raddr_o   = fetch_q[AW-1:0];
  assign rgray_o   = rgray_q;
  assign out_rdy_o = valid_q;
  assign dout_o    = dout_q;
endmodule

// File: rtl/xfifo_top.sv
module xfifo_top #(
  parameter int unsigned AW = xfifo_pkg::ADDR_W,
  parameter int unsigned DW = xfifo_pkg::DATA_W
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] af_ae_off_i,
  input  logic          rd_en_i,
  output logic          in_rdy_o,
  output logic          out_rdy_o,
  output logic [DW-1:0] rd_data_o,
  output logic          half_full_o,
  output logic          almost_o
);
  localparam int unsigned PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] rdata;
  logic [PW-1:0] wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;

  xfifo_wr_ctl #(.AW(AW)) u_wr (
    .clk_i     (wr_clk_i),
    .rst_ni    (rst_ni),
    .push_req_i(wr_en_i),
    .rgray_i   (rd_gray_ws),
    .off_cfg_i (af_ae_off_i),
    .we_o      (we),
    .waddr_o   (waddr),
    .wgray_o   (wr_gray),
    .in_rdy_o  (in_rdy_o),
    .half_o    (half_full_o),
    .almost_o  (almost_o)
  );

  xfifo_sync #(.W(PW), .STAGES(xfifo_pkg::SYNC_STAGES)) u_sync_r2w (
    .clk_i (wr_clk_i),
    .rst_ni(rst_ni),
    .d_i   (rd_gray),
    .q_o   (rd_gray_ws)
  );

  xfifo_sync #(.W(PW), .STAGES(xfifo_pkg::SYNC_STAGES)) u_sync_w2r (
    .clk_i (rd_clk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_gray),
    .q_o   (wr_gray_rs)
  );

  xfifo_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk_i (wr_clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  xfifo_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
    .clk_i    (rd_clk_i),
    .rst_ni   (rst_ni),
    .pop_req_i(rd_en_i),
    .wgray_i  (wr_gray_rs),
    .rdata_i  (rdata),
    .raddr_o  (raddr),
    .rgray_o  (rd_gray),
    .out_rdy_o(out_rdy_o),
    .dout_o   (rd_data_o)
  );
endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 18
) (
  input logic          wr_clk_i,
  input logic          rd_clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          in_rdy_o,
  input logic          out_rdy_o,
  input logic [DW-1:0] rd_data_o,
  input logic          half_full_o,
  input logic          almost_o,
  input logic [AW:0]   wr_gray,
  input logic [AW:0]   rd_gray
);
  assert_full_blocks_write_R2: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (!in_rdy_o && wr_en_i) |=> $stable(wr_gray));

  assert_empty_blocks_read_R3: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !out_rdy_o |=> $stable(rd_gray));

  assert_hold_last_R5: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !out_rdy_o |=> (out_rdy_o || $stable(rd_data_o)));

  assert_hold_unread_R6: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (out_rdy_o && !rd_en_i) |=> (out_rdy_o && $stable(rd_data_o)));

  assert_full_flags_R7: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !in_rdy_o |-> (half_full_o && almost_o));

  assert_wr_gray_step_R10: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  assert_rd_gray_step_R10: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind xfifo_top xfifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wr_clk_i   (wr_clk_i),
  .rd_clk_i   (rd_clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .in_rdy_o   (in_rdy_o),
  .out_rdy_o  (out_rdy_o),
  .rd_data_o  (rd_data_o),
  .half_full_o(half_full_o),
  .almost_o   (almost_o),
  .wr_gray    (wr_gray),
  .rd_gray    (rd_gray)
);

// File: tb/sim_xfifo_top.sv
`timescale 1ns/1ps
module sim_xfifo_top;
  localparam int AW    = 9;
  localparam int DW    = 18;
  localparam int DEPTH = 512;
  localparam int OFF   = 16;
  localparam int NT    = 9;

  // fill level -> expected half_full, almost
  localparam int unsigned tbl_lvl  [NT] = '{0, 10, 16, 17, 255, 256, 495, 496, 512};
  localparam bit          tbl_half [NT] = '{0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam bit          tbl_alm  [NT] = '{1, 1, 1, 0, 0, 0, 0, 1, 1};

  logic          wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic          wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] off = AW'(OFF);
  logic          in_rdy, out_rdy, half_full, almost;
  logic [DW-1:0] rd_data;

  int errs = 0, checks = 0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  xfifo_top u0 (
    .wr_clk_i   (wr_clk),
    .rd_clk_i   (rd_clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .af_ae_off_i(off),
    .rd_en_i    (rd_en),
    .in_rdy_o   (in_rdy),
    .out_rdy_o  (out_rdy),
    .rd_data_o  (rd_data),
    .half_full_o(half_full),
    .almost_o   (almost)
  );

  function automatic logic [DW-1:0] pat(input int i);
    logic [8:0] v = i[8:0];
    return {v, ~v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wr_n(input int from, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = pat(from + k);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge wr_clk);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    chk(1'b0, "R1 watchdog", 0, 1);
    summary();
  end

  initial begin
    int cur;
    bit seen;
    logic [DW-1:0] w1;
    repeat (4) @(negedge wr_clk);
    // R9 reset state
    chk(in_rdy == 1'b1,     "R9 in_rdy",    32'(in_rdy), 1);
    chk(out_rdy == 1'b0,    "R9 out_rdy",   32'(out_rdy), 0);
    chk(rd_data == '0,      "R9 rd_data",   32'(rd_data), 0);
    chk(half_full == 1'b0,  "R9 half_full", 32'(half_full), 0);
    chk(almost == 1'b1,     "R9 almost",    32'(almost), 1);
    @(negedge wr_clk);
    rst_n = 1'b1;

    // level table: fill with no reads
    cur = 0;
    for (int t = 0; t < NT; t++) begin
      wr_n(cur, int'(tbl_lvl[t]) - cur);
      cur = int'(tbl_lvl[t]);
      settle();
      chk(in_rdy == (cur < DEPTH), "R2 in_rdy vs level", 32'(in_rdy), 32'(cur < DEPTH));
      chk(half_full == tbl_half[t], "R7 half_full", 32'(half_full), 32'(tbl_half[t]));
      chk(almost == tbl_alm[t], "R8 almost", 32'(almost), 32'(tbl_alm[t]));
      if (cur > 0) begin
        chk(out_rdy == 1'b1, "R4 first word ready", 32'(out_rdy), 1);
        chk(rd_data == pat(0), "R6 first word held", 32'(rd_data), 32'(pat(0)));
      end
    end

    // R2 writes while full are dropped
    for (int k = 0; k < 3; k++) begin
      @(negedge wr_clk);
      wr_en   = 1'b1;
      wr_data = '1;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    settle();
    chk(in_rdy == 1'b0, "R2 still full", 32'(in_rdy), 0);

    // R1 drain in order across wrap
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge rd_clk);
      while (!out_rdy) @(negedge rd_clk);
      chk(rd_data == pat(i), "R1 order", 32'(rd_data), 32'(pat(i)));
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
    end
    settle();
    chk(out_rdy == 1'b0,   "R2 dropped words absent", 32'(out_rdy), 0);
    chk(rd_data == pat(DEPTH-1), "R5 last word held", 32'(rd_data), 32'(pat(DEPTH-1)));
    chk(in_rdy == 1'b1,    "R2 ready after drain", 32'(in_rdy), 1);
    chk(half_full == 1'b0, "R7 empty", 32'(half_full), 0);
    chk(almost == 1'b1,    "R8 empty", 32'(almost), 1);

    // R3 reads while empty are ignored
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (6) @(negedge rd_clk);
    rd_en = 1'b0;
    settle();
    chk(out_rdy == 1'b0, "R3 stays empty", 32'(out_rdy), 0);
    chk(rd_data == pat(DEPTH-1), "R3 data untouched", 32'(rd_data), 32'(pat(DEPTH-1)));
    chk(half_full == 1'b0, "R3 level not wrapped", 32'(half_full), 0);
    chk(in_rdy == 1'b1, "R3 in_rdy", 32'(in_rdy), 1);

    // R4 fall-through of a single word, edge by edge
    w1 = 18'h12345;
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = w1;
    @(negedge wr_clk);
    wr_en = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 20 && !seen; c++) begin
      @(negedge rd_clk);
      if (out_rdy) begin
        seen = 1'b1;
        chk(rd_data == w1, "R4 data with flag", 32'(rd_data), 32'(w1));
      end else if (rd_data != pat(DEPTH-1)) begin
        chk(1'b0, "R5 held before rise", 32'(rd_data), 32'(pat(DEPTH-1)));
      end
    end
    chk(seen, "R4 flag rose", 32'(seen), 1);

    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    settle();
    chk(out_rdy == 1'b0, "R5 empty after read", 32'(out_rdy), 0);
    chk(rd_data == w1,   "R5 single word held", 32'(rd_data), 32'(w1));
    chk(almost == 1'b1,  "R8 level zero", 32'(almost), 1);
    chk(half_full == 1'b0, "R7 level zero", 32'(half_full), 0);
    summary();
  end
endmodule